// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns the system clock into a one-cycle enable pulse, `tick_o`, at sixteen times the serial bit rate. The shared transmit and receive bit timing both hang off this pulse. The rate is set by a 22-bit divisor: a 16-bit integer part N and a 6-bit fraction F counted in 1/64 steps. Software picks the divisor as the clock frequency divided by sixteen times the wanted bit rate.

The period between ticks is N or N+1 clocks, never a fractional count. A 6-bit accumulator adds F at every tick. When that sum overflows, the next period is stretched by one clock. Across 64 ticks the fraction is therefore exact. This lets standard bit rates be reached closely from any clock.

Each part of the divisor has its own load port. A load on either port restarts the period counter and clears the accumulator, so the new rate starts from a known phase. An integer part of zero stops the ticks.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both divisor parts are zero and `tick_o` stays low.
- R2: While the integer part is 0, `tick_o` stays low whatever the fraction is.
- R3: With fraction 0 and integer part N ≥ 1, `tick_o` is high for one cycle in every N cycles. For N = 1 it is high in every cycle.
- R4: A load on either port restarts the period. The first tick comes in the N-th cycle after the load edge, with N counted from 1 at the first cycle after that edge. This holds even if the load arrives in the middle of a period.
- R5: Each period between two ticks is N+1 cycles if adding F to the 6-bit accumulator (cleared by a load) overflowed at the earlier tick. Otherwise the period is N cycles.
- R6: The 64 periods that follow the first tick after a load together last exactly 64·N + F cycles.
- R7: A load on one port leaves the other divisor part unchanged. Loads on both ports in the same cycle take both values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_wr_i | input | 1 | Load strobe for the integer part |
| int_data_i | input | 16 | Integer part N |
| frac_wr_i | input | 1 | Load strobe for the fraction |
| frac_data_i | input | 6 | Fraction F in 1/64 units |
| tick_o | output | 1 | One-cycle enable at 16× bit rate |

## Verification
If the period counter or the accumulator holds a wrong value, a tick appears too early or too late at `tick_o`. This shows within the current period. A wrong accumulator value shifts which of the next 64 periods get the extra clock. In that case the per-period pattern check fails first, and the 64-period total may still match. A restart that fails to clear state shows as a first tick earlier than N cycles after the load.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  parameter int unsigned DIV_INT_W  = 16;
  parameter int unsigned DIV_FRAC_W = 6;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_wr_i,
  input  logic [INT_W-1:0]  int_data_i,
  input  logic              frac_wr_i,
  input  logic [FRAC_W-1:0] frac_data_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              restart_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_o  <= '0;
      frac_o <= '0;
    end else begin
      if (int_wr_i)  int_o  <= int_data_i;
      if (frac_wr_i) frac_o <= frac_data_i;
    end
  end

  // clears period state at the same edge the new divisor lands
  assign restart_o = int_wr_i | frac_wr_i;
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              extra_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      extra_o <= 1'b0;
    end else if (clear_i) begin
      acc_q   <= '0;
      extra_o <= 1'b0;
    end else if (step_i) begin
      acc_q   <= sum[FRAC_W-1:0];
      extra_o <= sum[FRAC_W];
    end
  end
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
  parameter int unsigned INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [INT_W-1:0] int_i,
  input  logic             extra_i,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt_q;
  logic [INT_W:0]   last;
  logic             run;

  assign run    = (int_i != '0);
  assign last   = {1'b0, int_i} - 1'b1 + {{INT_W{1'b0}}, extra_i};
  assign tick_o = run && ({1'b0, cnt_q} == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || !run)    cnt_q <= '0;
    else if (tick_o)             cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned INT_W  = DIV_INT_W,
  parameter int unsigned FRAC_W = DIV_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_wr_i,
  input  logic [INT_W-1:0]  int_data_i,
  input  logic              frac_wr_i,
  input  logic [FRAC_W-1:0] frac_data_i,
  output logic              tick_o
);
  logic [INT_W-1:0]  div_int;
  logic [FRAC_W-1:0] div_frac;
  logic              restart;
  logic              extra;
  logic              tick;

  baud_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .int_wr_i    (int_wr_i),
    .int_data_i  (int_data_i),
    .frac_wr_i   (frac_wr_i),
    .frac_data_i (frac_data_i),
    .int_o       (div_int),
    .frac_o      (div_frac),
    .restart_o   (restart)
  );

  baud_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart),
    .step_i  (tick),
    .frac_i  (div_frac),
    .extra_o (extra)
  );

  baud_period_cnt #(.INT_W(INT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart),
    .int_i   (div_int),
    .extra_i (extra),
    .tick_o  (tick)
  );

  assign tick_o = tick;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              int_wr_i,
  input logic              frac_wr_i,
  input logic              tick_o,
  input logic [INT_W-1:0]  int_q,
  input logic [FRAC_W-1:0] frac_q
);
  logic [INT_W:0] gap_q;
  logic           wr;

  assign wr = int_wr_i | frac_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             gap_q <= '0;
    else if (wr || tick_o)   gap_q <= '0;
    else if (int_q != '0)    gap_q <= gap_q + 1'b1;
    else                     gap_q <= '0;
  end

  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_q == '0) |-> !tick_o); // R2

  AST_RESTART_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> (tick_o == (int_q == 1))); // R4

  AST_EXACT_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && frac_q == '0) |-> (gap_q + 1'b1 == {1'b0, int_q})); // R3

  AST_PERIOD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap_q + 1'b1 == {1'b0, int_q} || gap_q == {1'b0, int_q})); // R5

  AST_NO_LATE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && int_q != '0) |-> (gap_q < {1'b0, int_q})); // R5
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .int_wr_i  (int_wr_i),
  .frac_wr_i (frac_wr_i),
  .tick_o    (tick_o),
  .int_q     (div_int),
  .frac_q    (div_frac)
);

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        int_wr_i = 1'b0;
  logic [15:0] int_data_i = '0;
  logic        frac_wr_i = 1'b0;
  logic [5:0]  frac_data_i = '0;
  logic        tick_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cycles <= cycles + 1;

  baud_tick_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .int_wr_i(int_wr_i), .int_data_i(int_data_i),
    .frac_wr_i(frac_wr_i), .frac_data_i(frac_data_i),
    .tick_o(tick_o)
  );

  // {N, F}: expected first tick = N, 64-period sum = 64N+F
  localparam int NVEC = 6;
  localparam int VEC [NVEC][2] = '{
    '{3, 0}, '{5, 32}, '{2, 63}, '{7, 1}, '{1, 40}, '{10, 17}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input bit wi, input int n, input bit wf, input int f);
    @(negedge clk_i);
    int_wr_i = wi; int_data_i = 16'(n);
    frac_wr_i = wf; frac_data_i = 6'(f);
    @(posedge clk_i);
    #1;
    int_wr_i = 1'b0; frac_wr_i = 1'b0;
  endtask

  // samples from the load until the next tick, at negedges
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!tick_o && n < 100000);
  endtask

  // measure first tick, 64 periods vs accumulator model, and total
  task automatic run_rate(input string rf, input string rp, input string rs,
                          input int n, input int f);
    int first, per, sum, bad, acc, exp_p;
    wait_tick(first);
    check(rf, first, n);
    sum = 0; bad = 0; acc = 0;
    for (int k = 0; k < 64; k++) begin
      acc = acc + f;
      exp_p = n + ((acc >= 64) ? 1 : 0);
      acc = acc % 64;
      wait_tick(per);
      if (per != exp_p) bad++;
      sum += per;
    end
    check(rp, bad, 0);
    check(rs, sum, 64 * n + f);
  endtask

  initial begin
    int first, hits;
    fork
      begin
        repeat (150000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    // R1: reset state
    #1 check("R1 tick in reset", int'(tick_o), 0);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (tick_o) hits++;
    end
    check("R1 ticks after reset", hits, 0);

    // table of rates: R3/R4 first tick, R5 pattern, R6 total
    for (int v = 0; v < NVEC; v++) begin
      load(1, VEC[v][0], 1, VEC[v][1]);
      run_rate("R4 first tick", "R5 period pattern", "R6 64-period sum",
               VEC[v][0], VEC[v][1]);
    end

    // R2: integer zero stops ticks
    load(1, 0, 1, 5);
    hits = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (tick_o) hits++;
    end
    check("R2 ticks with N=0", hits, 0);

    // R3: N=1, F=0 ticks every cycle
    load(1, 1, 1, 0);
    hits = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (tick_o) hits++;
    end
    check("R3 N=1 continuous", hits, 10);

    // R4: restart mid-period
    load(1, 20, 1, 0);
    repeat (7) @(negedge clk_i);
    load(1, 20, 0, 0);
    wait_tick(first);
    check("R4 restart mid-period", first, 20);

    // R7: fraction-only load keeps N, integer-only load keeps F
    load(1, 4, 1, 0);
    load(0, 0, 1, 16);
    run_rate("R7 first tick frac-only", "R7 pattern frac-only", "R7 sum frac-only", 4, 16);
    load(1, 6, 0, 0);
    run_rate("R7 first tick int-only", "R7 pattern int-only", "R7 sum int-only", 6, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule